// File: doc/BRIEF.md
# Denormal single-to-double widening unit

This unit takes a 32-bit single-precision word and, when that word is a subnormal single, rebuilds it as a normal 64-bit double. The double is delivered as two 32-bit words: an upper word carrying sign, exponent and the high fraction bits, and a lower word carrying the remaining fraction bits. A floating-point trap path uses it to repair a widening conversion that the main datapath refused because its operand was subnormal.

Normalization is iterative. The fraction is moved left one bit per clock until its leading one reaches the hidden-bit position, bit 23. The exponent starts at 897 and drops by one for each move. A controller with three states sequences the work:

- `S_IDLE` waits for `start_i`.
- `S_NORM` performs the shifts.
- `S_EMIT` raises `done_o` for one cycle.

The transitions are:

- **accept-denormal:** `S_IDLE`→`S_NORM`, on start with a subnormal operand.
- **accept-skip:** `S_IDLE`→`S_EMIT`, on start with any other operand.
- **normalized:** `S_NORM`→`S_EMIT`, when the next shift brings the leading one to bit 23.
- **retire:** `S_EMIT`→`S_IDLE`, unconditionally.

Any operand that is not subnormal completes at once with `converted_o` low and leaves the result words untouched. This covers positive and negative zero, normal values, infinities and NaNs. The unit does no rounding, because widening a single to a double is exact.

Top module: `sp_denorm_widen`

## Requirements
- R1: An operand is converted only when bits 30:23 are all zero and bits 22:0 are not all zero. Every other operand, including 0x80000000, finishes with `converted_o` = 0.
- R2: For a converted operand, `hi_word_o[31]` equals operand bit 31.
- R3: For a converted operand, `hi_word_o[30:20]` equals 897 − k, where k is the number of left shifts that bring the operand's highest set fraction bit to bit 23. k lies between 1 and 23, so the field lies between 874 and 896.
- R4: For a converted operand, let F be the 23 bits below the leading one after normalization. Then `hi_word_o[19:0]` = F[22:3], `lo_word_o[31:29]` = F[2:0], and `lo_word_o[28:0]` = 0.
- R5: The unit performs one shift per clock. `done_o` is seen k+1 rising edges after the accepting edge for a converted operand, and 1 edge after for any other operand. The worst case is 24.
- R6: `done_o` is high for exactly one cycle. `converted_o` is valid while `done_o` is high and holds its value until the next completion.
- R7: A completion with `converted_o` = 0 leaves `hi_word_o` and `lo_word_o` at their previous values.
- R8: `busy_o` is high from the cycle after acceptance through the `done_o` cycle. A `start_i` during that time is ignored: it does not change the result or the timing, and it causes no extra completion.
- R9: After reset, `busy_o`, `done_o` and `converted_o` are 0, and both result words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to process `value_i`; only honoured when not busy |
| value_i | input | 32 | Single-precision operand, sampled with `start_i` |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| converted_o | output | 1 | Last completion produced a new double |
| hi_word_o | output | 32 | Double bits 63:32 (sign, exponent, high fraction) |
| lo_word_o | output | 32 | Double bits 31:0 (low fraction) |

## Verification
The operands are chosen so that each one separates a different behaviour:

- **Shift-count extremes:**
  - 0x00400000 and 0x007FFFFF both need one shift.
  - 0x80000001 needs twenty-three shifts.
  - 0x00000007 needs twenty-one shifts.

  Together these pin the exponent arithmetic and the latency count at both ends.
- **Fraction split:** 0x007FFFFF and 0x80200005 leave set bits below bit 3 after normalization. They show whether the fraction is divided correctly between the two words and whether the sign is carried through.
- **Rejected operands:** each is placed right after a converted one, so a result that is wrongly overwritten becomes visible. They are:
  - positive zero and negative zero;
  - a normal value;
  - an infinity;
  - a NaN.
- **Ignored starts:** a start raised in the middle of a long normalization, and another raised during the done cycle, show whether requests arriving while busy are dropped.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int SP_BIAS   = 127;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int DP_BIAS   = 1023;
    localparam int WORD_W    = 32;
    // derived
    localparam int EXP_START = DP_BIAS - (SP_BIAS - 1);
    localparam int EXP_MIN   = EXP_START - SP_FRAC_W;
    localparam int EXP_MAX   = EXP_START - 1;
    localparam int HI_FRAC_W = DP_FRAC_W - WORD_W;
    localparam int PAD_W     = DP_FRAC_W - SP_FRAC_W;
    localparam int MANT_W    = SP_FRAC_W + 1;

    typedef logic [DP_EXP_W-1:0]  dexp_t;
    typedef logic [SP_FRAC_W-1:0] sfrac_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_NORM = 2'd1,
        S_EMIT = 2'd2
    } sdw_state_e;
endpackage

// File: rtl/sdw_classify.sv
module sdw_classify
    import sdw_pkg::*;
(
    input  logic [SP_W-1:0] value_i,
    output logic            sign_o,
    output sfrac_t          frac_o,
    output logic            is_sub_o
);
    logic [SP_EXP_W-1:0] exp_field;

    always_comb begin
        sign_o    = value_i[SP_W-1];
        exp_field = value_i[SP_W-2 -: SP_EXP_W];
        frac_o    = value_i[SP_FRAC_W-1:0];
        // R1: zero exponent field and a non-empty fraction
        is_sub_o  = (exp_field == '0) && (frac_o != '0);
    end
endmodule

// File: rtl/sdw_normalize.sv
module sdw_normalize
    import sdw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  logic   shift_i,
    input  logic   sign_i,
    input  sfrac_t frac_i,
    output logic   lead_next_o,
    output logic   sign_o,
    output sfrac_t frac_next_o,
    output dexp_t  exp_next_o
);
    logic [MANT_W-1:0] mant_q;
    dexp_t             exp_q;
    logic              sign_q;
    logic [MANT_W-1:0] mant_shl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mant_q <= '0;
            exp_q  <= '0;
            sign_q <= 1'b0;
        end else if (load_i) begin
            mant_q <= {1'b0, frac_i};
            exp_q  <= dexp_t'(EXP_START);
            sign_q <= sign_i;
        end else if (shift_i) begin
            mant_q <= mant_shl;
            exp_q  <= exp_q - dexp_t'(1);
        end
    end

    always_comb begin
        mant_shl    = {mant_q[MANT_W-2:0], 1'b0};
        lead_next_o = mant_q[SP_FRAC_W-1];
        frac_next_o = mant_shl[SP_FRAC_W-1:0];
        exp_next_o  = exp_q - dexp_t'(1);
        sign_o      = sign_q;
    end

    // R3: each shift lowers the exponent by exactly one
    a_r3_exp_step: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (exp_q == $past(exp_q) - dexp_t'(1)));

    // R5: a shift never runs on an empty mantissa (bounded loop)
    a_r5_no_empty_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> (mant_q != '0));
endmodule

// File: rtl/sdw_pack.sv
module sdw_pack
    import sdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              skip_i,
    input  logic              sign_i,
    input  dexp_t             exp_i,
    input  sfrac_t            frac_i,
    output logic [WORD_W-1:0] hi_o,
    output logic [WORD_W-1:0] lo_o,
    output logic              conv_o
);
    logic [DP_FRAC_W-1:0] dp_frac;

    always_comb dp_frac = {frac_i, {PAD_W{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_o   <= '0;
            lo_o   <= '0;
            conv_o <= 1'b0;
        end else if (capture_i) begin
            hi_o   <= {sign_i, exp_i, dp_frac[DP_FRAC_W-1 -: HI_FRAC_W]};
            lo_o   <= dp_frac[WORD_W-1:0];
            conv_o <= 1'b1;
        end else if (skip_i) begin
            conv_o <= 1'b0;
        end
    end

    // R7: a skip never coincides with a capture
    a_r7_skip_excl: assert property (@(posedge clk) disable iff (!rst_n)
        skip_i |-> !capture_i);
endmodule

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
    import sdw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic is_sub_i,
    input  logic lead_next_i,
    output logic load_o,
    output logic skip_o,
    output logic shift_o,
    output logic capture_o,
    output logic done_o,
    output logic busy_o
);
    sdw_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (start_i) st_d = is_sub_i ? S_NORM : S_EMIT;
            S_NORM: if (lead_next_i) st_d = S_EMIT;
            S_EMIT: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_comb begin
        load_o    = 1'b0;
        skip_o    = 1'b0;
        shift_o   = 1'b0;
        capture_o = 1'b0;
        done_o    = 1'b0;
        busy_o    = 1'b1;
        unique case (st_q)
            S_IDLE: begin
                busy_o = 1'b0;
                load_o = start_i && is_sub_i;
                skip_o = start_i && !is_sub_i;
            end
            S_NORM: begin
                shift_o   = 1'b1;
                capture_o = lead_next_i;
            end
            S_EMIT: done_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    // R8: a normalization in progress is never abandoned back to idle
    a_r8_norm_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_NORM) |=> (st_q != S_IDLE));

    // R5: the emit state always lasts one cycle
    a_r5_emit_once: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EMIT) |=> (st_q == S_IDLE));
endmodule

// File: rtl/sp_denorm_widen.sv
module sp_denorm_widen
    import sdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SP_W-1:0]   value_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              converted_o,
    output logic [WORD_W-1:0] hi_word_o,
    output logic [WORD_W-1:0] lo_word_o
);
    logic   in_sign, in_sub;
    sfrac_t in_frac;
    logic   load, skip, shift, capture, lead_next, nrm_sign;
    sfrac_t nrm_frac;
    dexp_t  nrm_exp;

    sdw_classify u_classify (
        .value_i  (value_i),
        .sign_o   (in_sign),
        .frac_o   (in_frac),
        .is_sub_o (in_sub)
    );

    sdw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .is_sub_i    (in_sub),
        .lead_next_i (lead_next),
        .load_o      (load),
        .skip_o      (skip),
        .shift_o     (shift),
        .capture_o   (capture),
        .done_o      (done_o),
        .busy_o      (busy_o)
    );

    sdw_normalize u_norm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .shift_i     (shift),
        .sign_i      (in_sign),
        .frac_i      (in_frac),
        .lead_next_o (lead_next),
        .sign_o      (nrm_sign),
        .frac_next_o (nrm_frac),
        .exp_next_o  (nrm_exp)
    );

    sdw_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .skip_i    (skip),
        .sign_i    (nrm_sign),
        .exp_i     (nrm_exp),
        .frac_i    (nrm_frac),
        .hi_o      (hi_word_o),
        .lo_o      (lo_word_o),
        .conv_o    (converted_o)
    );

    // R6: completion strobe is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: a rejected operand leaves both result words as they were
    a_r7_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !converted_o) |-> ($stable(hi_word_o) && $stable(lo_word_o)));

    // R3: produced exponent lies within the subnormal-derived range
    a_r3_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && converted_o) |->
            ((hi_word_o[WORD_W-2 -: DP_EXP_W] >= dexp_t'(EXP_MIN)) &&
             (hi_word_o[WORD_W-2 -: DP_EXP_W] <= dexp_t'(EXP_MAX))));

    // R4: low fraction bits below the retained fraction stay clear
    a_r4_lo_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lo_word_o[WORD_W-4:0] == '0));
endmodule

// File: tb/sp_denorm_widen_tb.sv
module sp_denorm_widen_tb;
    localparam int NV = 10;
    // operand, expected hi, expected lo, converted, latency in edges
    localparam logic [31:0] V_IN [NV] = '{
        32'h00400000, 32'h3F800000, 32'h007FFFFF, 32'h00000000, 32'h80000001,
        32'h80000000, 32'h00000007, 32'h7F800001, 32'h80200005, 32'hFF800000};
    localparam logic [31:0] V_HI [NV] = '{
        32'h38000000, 32'h38000000, 32'h380FFFFF, 32'h380FFFFF, 32'hB6A00000,
        32'hB6A00000, 32'h36CC0000, 32'h36CC0000, 32'hB7F00002, 32'hB7F00002};
    localparam logic [31:0] V_LO [NV] = '{
        32'h00000000, 32'h00000000, 32'hC0000000, 32'hC0000000, 32'h00000000,
        32'h00000000, 32'h00000000, 32'h00000000, 32'h80000000, 32'h80000000};
    localparam logic V_CV [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam int V_LAT [NV] = '{2, 1, 2, 1, 24, 1, 22, 1, 3, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] value_i = '0;
    logic        busy_o, done_o, converted_o;
    logic [31:0] hi_word_o, lo_word_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sp_denorm_widen u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
        .busy_o(busy_o), .done_o(done_o), .converted_o(converted_o),
        .hi_word_o(hi_word_o), .lo_word_o(lo_word_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // start at a negedge, return edges until done is seen at a negedge
    task automatic launch(input logic [31:0] v, output int lat);
        value_i = v;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 60) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 busy", {31'b0, busy_o}, 32'd0);
        check("R9 done", {31'b0, done_o}, 32'd0);
        check("R9 converted", {31'b0, converted_o}, 32'd0);
        check("R9 hi", hi_word_o, 32'd0);
        check("R9 lo", lo_word_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            launch(V_IN[i], lat);
            check("R5 latency", lat, V_LAT[i]);
            check("R1 converted", {31'b0, converted_o}, {31'b0, V_CV[i]});
            check(V_CV[i] ? "R2/R3/R4 hi" : "R7 hi held", hi_word_o, V_HI[i]);
            check(V_CV[i] ? "R4 lo" : "R7 lo held", lo_word_o, V_LO[i]);
            @(negedge clk);
            check("R6 done pulse", {31'b0, done_o}, 32'd0);
            check("R6 converted held", {31'b0, converted_o}, {31'b0, V_CV[i]});
        end

        // R8: start mid-normalization is ignored
        value_i = 32'h80000001;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) begin @(posedge clk); @(negedge clk); end
        check("R8 busy during shift", {31'b0, busy_o}, 32'd1);
        value_i = 32'h00400000;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 6;
        while (!done_o && lat < 60) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check("R8 latency unchanged", lat, 24);
        check("R8 hi unchanged", hi_word_o, 32'hB6A00000);
        // R8: start raised during the done cycle is ignored
        check("R8 busy in done cycle", {31'b0, busy_o}, 32'd1);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R8 no accept busy", {31'b0, busy_o}, 32'd0);
        check("R8 no accept done", {31'b0, done_o}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        check("R8 no extra done", {31'b0, done_o}, 32'd0);
        check("R8 words intact", hi_word_o, 32'hB6A00000);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end
endmodule